// File: doc/BRIEF.md
# Load/Store Address and Alignment Front End

This block sits between a 32-bit register file and a 32-bit on-chip data bus and handles every memory instruction. It computes the effective address from a base operand plus either an index operand or a sign-extended 16-bit offset. A flag on the instruction can force the base to zero. It then drives one bus beat per word. Byte and half-word stores get byte enables and replicated data. Returned load data are aligned and extended to a full register word before they are handed back.

A new memory instruction can be accepted on every clock. A single-word access returns its data two clocks after issue. A double-word access is broken into two back-to-back word beats at the effective address and at the next word. Its two result words come back in order, two and three clocks after issue, and a flag marks the second one. The only issue stall is the one cycle in which the second beat of a double word holds the bus. The bus is treated as a memory port that answers a read one clock after the request.

Top module: `ldst_front`

## Requirements
- R1: The effective address is the base operand (or zero when `iss_base_zero` is 1) plus the index operand (when `iss_use_imm` is 0) or the immediate (when `iss_use_imm` is 1). `bus_addr` carries this address with its two low bits cleared.
- R2: The 16-bit immediate is sign-extended to 32 bits before it is added.
- R3: Size codes are 0 = byte, 1 = half word, 2 = word and 3 = double word. A word load accepted at a clock edge gives `res_valid` with the full bus word two edges later, and the bus beat appears one edge after acceptance.
- R4: A double-word access drives two consecutive beats, at the aligned address and at that address plus 4. Its loads return two results in order, with `res_second` at 0 and then 1, two and three edges after acceptance.
- R5: A byte load returns the selected byte zero-filled in bits 31:8. Lanes are big-endian: address offset 0 selects bus bits 31:24 and offset 3 selects bits 7:0.
- R6: A half-word load takes bus bits 31:16 when address bit 1 is 0, and bits 15:0 when it is 1. It is sign-extended when `iss_signed` is 1 and zero-filled otherwise.
- R7: Byte enable bit 3 covers bus bits 31:24. A byte access enables only bit 3 minus the offset, a half word enables 1100 (bit 1 = 0) or 0011 (bit 1 = 1), and a word enables 1111. Byte store data are replicated into all four lanes and half-word store data into both halves.
- R8: A double-word store writes `iss_wdata` in the first beat and `iss_wdata_hi` in the second, with all byte enables set in both.
- R9: `iss_ready` is low only in the single cycle after a double word is accepted. Any other sequence of instructions is accepted one per cycle.
- R10: Stores produce no result: `res_valid` stays low for them.
- R11: During and right after reset, `bus_req` and `res_valid` are 0 and `iss_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Memory instruction offered |
| iss_ready | output | 1 | Instruction accepted this cycle when valid |
| iss_store | input | 1 | 1 = store, 0 = load |
| iss_size | input | 2 | 0 byte, 1 half, 2 word, 3 double word |
| iss_signed | input | 1 | Sign-extend half-word loads |
| iss_base_zero | input | 1 | Use zero in place of the base operand |
| iss_use_imm | input | 1 | Add the immediate instead of the index |
| iss_base | input | 32 | Base operand |
| iss_index | input | 32 | Index operand |
| iss_imm | input | 16 | Signed offset |
| iss_wdata | input | 32 | Store data (first word) |
| iss_wdata_hi | input | 32 | Second store word of a double word |
| bus_req | output | 1 | Bus beat valid |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | 32 | Word-aligned beat address |
| bus_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, one clock after the request |
| res_valid | output | 1 | Load result valid |
| res_second | output | 1 | Result is the second word of a double word |
| res_data | output | 32 | Aligned and extended load data |

## Verification
The interesting overlap is a store's bus beat in the same cycle as the formatting of an earlier load's returned word. A second overlap is a double word's second beat on the bus while the result of its first beat is delivered and the next instruction waits. The bench provokes both with a back-to-back stream: word load, double-word load, byte load, word store, then a load of the stored word. It requires exactly one issue stall, each result at its predicted cycle and with its predicted value, and a final memory image that matches a model built from the store semantics alone.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } ldst_size_e;
endpackage

// File: rtl/ldst_ea_gen.sv
module ldst_ea_gen #(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic              base_zero,
   input  logic              use_imm,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] index,
   input  logic [IMM_W-1:0]  imm,
   output logic [ADDR_W-1:0] ea
);
   localparam int EXT_W = ADDR_W - IMM_W;

   generate
      if (IMM_W >= ADDR_W) begin : g_bad_imm
         $error("ldst_ea_gen: IMM_W must be narrower than ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] base_op;
   logic [ADDR_W-1:0] off_op;

   always_comb begin
      base_op = base_zero ? '0 : base;
      off_op  = use_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : index;
      ea      = base_op + off_op;
   end
endmodule

// File: rtl/ldst_beat_seq.sv
module ldst_beat_seq
   import ldst_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_fire,
   input  logic              iss_store,
   input  logic [1:0]        iss_size,
   input  logic              iss_signed,
   input  logic [ADDR_W-1:0] ea,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] wdata_hi,
   output logic              iss_ready,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W/8-1:0] bus_be,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [1:0]        bus_size,
   output logic              bus_signed,
   output logic [$clog2(DATA_W/8)-1:0] bus_off,
   output logic              bus_second
);
   localparam int NLANE = DATA_W / 8;
   localparam int OFF_W = $clog2(NLANE);
   localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(NLANE);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("ldst_beat_seq: lane layout assumes a 32-bit bus");
      end
   endgenerate

   logic [OFF_W-1:0]  lane_off;
   logic [NLANE-1:0]  be_byte, be_half, be_new;
   logic [DATA_W-1:0] wd_byte, wd_half, wd_new;
   logic              pend2;
   logic [DATA_W-1:0] hold_hi;

   assign lane_off = ea[OFF_W-1:0];

   generate
      for (genvar l = 0; l < NLANE; l++) begin : g_lane
         assign be_byte[l]       = (lane_off == OFF_W'(NLANE - 1 - l));
         assign be_half[l]       = (l < NLANE / 2) ? lane_off[OFF_W-1] : ~lane_off[OFF_W-1];
         assign wd_byte[8*l +: 8] = wdata[7:0];
      end
      for (genvar h = 0; h < NLANE / 2; h++) begin : g_half
         assign wd_half[16*h +: 16] = wdata[15:0];
      end
   endgenerate

   always_comb begin
      unique case (iss_size)
         SZ_BYTE: begin be_new = be_byte; wd_new = wd_byte; end
         SZ_HALF: begin be_new = be_half; wd_new = wd_half; end
         default: begin be_new = '1;      wd_new = wdata;   end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_req    <= 1'b0;
         bus_we     <= 1'b0;
         bus_addr   <= '0;
         bus_be     <= '0;
         bus_wdata  <= '0;
         bus_size   <= '0;
         bus_signed <= 1'b0;
         bus_off    <= '0;
         bus_second <= 1'b0;
         pend2      <= 1'b0;
         hold_hi    <= '0;
      end else if (iss_fire) begin
         bus_req    <= 1'b1;
         bus_we     <= iss_store;
         bus_addr   <= {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
         bus_be     <= be_new;
         bus_wdata  <= wd_new;
         bus_size   <= iss_size;
         bus_signed <= iss_signed;
         bus_off    <= lane_off;
         bus_second <= 1'b0;
         pend2      <= (iss_size == SZ_DWORD);
         hold_hi    <= wdata_hi;
      end else if (bus_req && pend2) begin
         bus_addr   <= bus_addr + BEAT_STEP;
         bus_be     <= '1;
         bus_wdata  <= hold_hi;
         bus_second <= 1'b1;
         pend2      <= 1'b0;
      end else begin
         bus_req    <= 1'b0;
         bus_second <= 1'b0;
         pend2      <= 1'b0;
      end
   end

   assign iss_ready = !(bus_req && pend2);

   // R4
   dword_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && pend2) |=> (bus_req && bus_second && bus_addr == $past(bus_addr) + BEAT_STEP
                              && bus_we == $past(bus_we)));

   // R9
   single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_ready |=> iss_ready);

   // R7
   byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_size == SZ_BYTE) |-> $countones(bus_be) == 1);
endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt
   import ldst_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [1:0]        bus_size,
   input  logic              bus_signed,
   input  logic [$clog2(DATA_W/8)-1:0] bus_off,
   input  logic              bus_second,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              res_valid,
   output logic              res_second,
   output logic [DATA_W-1:0] res_data
);
   localparam int NLANE  = DATA_W / 8;
   localparam int OFF_W  = $clog2(NLANE);
   localparam int HALF_W = DATA_W / 2;

   logic [1:0]       r_size;
   logic             r_signed;
   logic [OFF_W-1:0] r_off;
   logic [OFF_W-1:0] lane;
   logic [7:0]       byte_v;
   logic [HALF_W-1:0] half_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_second <= 1'b0;
         r_size     <= '0;
         r_signed   <= 1'b0;
         r_off      <= '0;
      end else begin
         res_valid  <= bus_req && !bus_we;
         res_second <= bus_second;
         r_size     <= bus_size;
         r_signed   <= bus_signed;
         r_off      <= bus_off;
      end
   end

   always_comb begin
      lane   = ~r_off;
      byte_v = bus_rdata[lane*8 +: 8];
      half_v = r_off[OFF_W-1] ? bus_rdata[HALF_W-1:0] : bus_rdata[DATA_W-1:HALF_W];
      unique case (r_size)
         SZ_BYTE: res_data = {{(DATA_W-8){1'b0}}, byte_v};
         SZ_HALF: res_data = {{HALF_W{r_signed & half_v[HALF_W-1]}}, half_v};
         default: res_data = bus_rdata;
      endcase
   end

   // R3
   load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> res_valid);

   // R10
   store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |=> !res_valid);

   // R5
   byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && r_size == SZ_BYTE) |-> res_data[DATA_W-1:8] == '0);
endmodule

// File: rtl/ldst_front.sv
module ldst_front #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                iss_valid,
   output logic                iss_ready,
   input  logic                iss_store,
   input  logic [1:0]          iss_size,
   input  logic                iss_signed,
   input  logic                iss_base_zero,
   input  logic                iss_use_imm,
   input  logic [ADDR_W-1:0]   iss_base,
   input  logic [ADDR_W-1:0]   iss_index,
   input  logic [IMM_W-1:0]    iss_imm,
   input  logic [DATA_W-1:0]   iss_wdata,
   input  logic [DATA_W-1:0]   iss_wdata_hi,
   output logic                bus_req,
   output logic                bus_we,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [DATA_W/8-1:0] bus_be,
   output logic [DATA_W-1:0]   bus_wdata,
   input  logic [DATA_W-1:0]   bus_rdata,
   output logic                res_valid,
   output logic                res_second,
   output logic [DATA_W-1:0]   res_data
);
   localparam int OFF_W = $clog2(DATA_W / 8);

   logic              iss_fire;
   logic [ADDR_W-1:0] ea;
   logic [1:0]        bus_size;
   logic              bus_signed;
   logic [OFF_W-1:0]  bus_off;
   logic              bus_second;

   assign iss_fire = iss_valid && iss_ready;

   ldst_ea_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_ea (
      .base_zero (iss_base_zero),
      .use_imm   (iss_use_imm),
      .base      (iss_base),
      .index     (iss_index),
      .imm       (iss_imm),
      .ea        (ea)
   );

   ldst_beat_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .iss_fire   (iss_fire),
      .iss_store  (iss_store),
      .iss_size   (iss_size),
      .iss_signed (iss_signed),
      .ea         (ea),
      .wdata      (iss_wdata),
      .wdata_hi   (iss_wdata_hi),
      .iss_ready  (iss_ready),
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_be     (bus_be),
      .bus_wdata  (bus_wdata),
      .bus_size   (bus_size),
      .bus_signed (bus_signed),
      .bus_off    (bus_off),
      .bus_second (bus_second)
   );

   ldst_load_fmt #(.DATA_W(DATA_W)) u_fmt (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_size   (bus_size),
      .bus_signed (bus_signed),
      .bus_off    (bus_off),
      .bus_second (bus_second),
      .bus_rdata  (bus_rdata),
      .res_valid  (res_valid),
      .res_second (res_second),
      .res_data   (res_data)
   );

   // R9
   accept_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_fire |=> (bus_req && !bus_second));
endmodule

// File: tb/ldst_front_bench.sv
module ldst_front_bench;
   typedef struct packed {
      logic        st;
      logic [1:0]  sz;
      logic        sg;
      logic        bz;
      logic        im;
      logic [31:0] base;
      logic [31:0] idx;
      logic [15:0] imm;
      logic [31:0] wd;
      logic [31:0] wh;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 32'h40,        32'h0,  16'h0008, 32'h0, 32'h0},
      '{1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 32'h10,        32'h20, 16'h7777, 32'h0, 32'h0},
      '{1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 32'hDEADBEEF,  32'h0,  16'h0024, 32'h0, 32'h0},
      '{1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 32'h80,        32'h0,  16'hFFF0, 32'h0, 32'h0},
      '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h50,        32'h0,  16'h0000, 32'h0, 32'h0},
      '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h50,        32'h3,  16'h0000, 32'h0, 32'h0},
      '{1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 32'h60,        32'h0,  16'h0000, 32'h0, 32'h0},
      '{1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 32'h60,        32'h0,  16'h0002, 32'h0, 32'h0},
      '{1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 32'h60,        32'h0,  16'h0000, 32'h0, 32'h0},
      '{1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 32'h88,        32'h0,  16'h0000, 32'h0, 32'h0},
      '{1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 32'hA0,        32'h0,  16'h0001, 32'h123456C7, 32'h0},
      '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 32'hB0,        32'h2,  16'h0000, 32'h9876ABCD, 32'h0},
      '{1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 32'h5555,      32'h0,  16'h00C0, 32'hCAFEF00D, 32'h0},
      '{1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 32'hD0,        32'h0,  16'h0000, 32'h01234567, 32'h89ABCDEF},
      '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 32'hA0,        32'h0,  16'h0001, 32'h0, 32'h0},
      '{1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 32'hD0,        32'h0,  16'h0000, 32'h0, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0, iss_store = 1'b0, iss_signed = 1'b0;
   logic        iss_base_zero = 1'b0, iss_use_imm = 1'b0;
   logic [1:0]  iss_size = 2'd0;
   logic [31:0] iss_base = '0, iss_index = '0, iss_wdata = '0, iss_wdata_hi = '0;
   logic [15:0] iss_imm = '0;
   logic        iss_ready, bus_req, bus_we, res_valid, res_second;
   logic [31:0] bus_addr, bus_wdata, res_data;
   logic [3:0]  bus_be;
   logic [31:0] bus_rdata = '0;

   logic [31:0] mem [64];
   logic [31:0] ref_mem [64];
   int cyc = 0;
   int n_tests = 0, n_fail = 0;

   logic [31:0] eb_addr_q[$], eb_data_q[$];
   logic [3:0]  eb_be_q[$];
   logic        eb_we_q[$];
   int          eb_cyc_q[$];
   string       eb_tag_q[$];
   logic [31:0] er_data_q[$];
   logic        er_sec_q[$];
   int          er_cyc_q[$];
   string       er_tag_q[$];

   ldst_front u_ldst_front (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_store(iss_store), .iss_size(iss_size), .iss_signed(iss_signed),
      .iss_base_zero(iss_base_zero), .iss_use_imm(iss_use_imm), .iss_base(iss_base),
      .iss_index(iss_index), .iss_imm(iss_imm), .iss_wdata(iss_wdata),
      .iss_wdata_hi(iss_wdata_hi), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .res_valid(res_valid), .res_second(res_second),
      .res_data(res_data)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      if (bus_req) begin
         bus_rdata <= mem[bus_addr[7:2]];
         if (bus_we)
            for (int l = 0; l < 4; l++)
               if (bus_be[l]) mem[bus_addr[7:2]][8*l +: 8] <= bus_wdata[8*l +: 8];
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] sel_load(input logic [31:0] w, input logic [1:0] sz,
                                            input logic sg, input logic [1:0] off);
      logic [15:0] h;
      case (sz)
         2'd0: return {24'h0, w[8*(3-off) +: 8]};
         2'd1: begin
            h = off[1] ? w[15:0] : w[31:16];
            return {{16{sg & h[15]}}, h};
         end
         default: return w;
      endcase
   endfunction

   task automatic push_bus(input logic [31:0] a, input logic we, input logic [3:0] be,
                           input logic [31:0] d, input int c, input string tag);
      eb_addr_q.push_back(a); eb_we_q.push_back(we); eb_be_q.push_back(be);
      eb_data_q.push_back(d); eb_cyc_q.push_back(c); eb_tag_q.push_back(tag);
   endtask

   task automatic push_res(input logic [31:0] d, input logic s, input int c, input string tag);
      er_data_q.push_back(d); er_sec_q.push_back(s); er_cyc_q.push_back(c); er_tag_q.push_back(tag);
   endtask

   // Expected behaviour built from R1, R2 and R4..R8
   task automatic expect_for(input vec_t v, input int acc, input string tag);
      logic [31:0] ea, a0, a1, wd;
      logic [3:0]  be;
      ea = (v.bz ? 32'h0 : v.base) + (v.im ? {{16{v.imm[15]}}, v.imm} : v.idx);
      a0 = {ea[31:2], 2'b00};
      a1 = a0 + 32'd4;
      case (v.sz)
         2'd0: begin be = 4'b1000 >> ea[1:0]; wd = {4{v.wd[7:0]}}; end
         2'd1: begin be = ea[1] ? 4'b0011 : 4'b1100; wd = {2{v.wd[15:0]}}; end
         default: begin be = 4'b1111; wd = v.wd; end
      endcase
      push_bus(a0, v.st, be, wd, acc + 1, tag);
      if (v.sz == 2'd3) push_bus(a1, v.st, 4'b1111, v.wh, acc + 2, tag);
      if (v.st) begin
         for (int l = 0; l < 4; l++)
            if (be[l]) ref_mem[a0[7:2]][8*l +: 8] = wd[8*l +: 8];
         if (v.sz == 2'd3) ref_mem[a1[7:2]] = v.wh;
      end else begin
         push_res(sel_load(ref_mem[a0[7:2]], v.sz, v.sg, ea[1:0]), 1'b0, acc + 2, tag);
         if (v.sz == 2'd3) push_res(ref_mem[a1[7:2]], 1'b1, acc + 3, tag);
      end
   endtask

   task automatic issue(input vec_t v, input string tag, output int stalls);
      int acc;
      logic rdy;
      stalls = 0;
      @(negedge clk);
      iss_valid = 1'b1; iss_store = v.st; iss_size = v.sz; iss_signed = v.sg;
      iss_base_zero = v.bz; iss_use_imm = v.im; iss_base = v.base; iss_index = v.idx;
      iss_imm = v.imm; iss_wdata = v.wd; iss_wdata_hi = v.wh;
      forever begin
         rdy = iss_ready;
         acc = cyc;
         @(posedge clk);
         if (rdy) break;
         @(negedge clk);
         stalls++;
      end
      expect_for(v, acc, tag);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      iss_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_req) begin
            if (eb_addr_q.size() == 0) chk(1'b0, "R1", "unexpected bus beat", bus_addr, 32'h0);
            else begin
               automatic string t = eb_tag_q.pop_front();
               automatic logic [31:0] ea0 = eb_addr_q.pop_front();
               automatic logic we0 = eb_we_q.pop_front();
               automatic logic [3:0] be0 = eb_be_q.pop_front();
               automatic logic [31:0] d0 = eb_data_q.pop_front();
               automatic int c0 = eb_cyc_q.pop_front();
               chk(bus_addr == ea0, {t, "/R1"}, "bus address", bus_addr, ea0);
               chk(bus_we == we0, t, "bus write flag", {31'h0, bus_we}, {31'h0, we0});
               chk(bus_be == be0, {t, "/R7"}, "byte enables", {28'h0, bus_be}, {28'h0, be0});
               if (we0) chk(bus_wdata == d0, {t, "/R8"}, "write data", bus_wdata, d0);
               chk(cyc == c0, {t, "/R3"}, "beat cycle", cyc, c0);
            end
         end
         if (res_valid) begin
            if (er_data_q.size() == 0) chk(1'b0, "R10", "unexpected result", res_data, 32'h0);
            else begin
               automatic string t = er_tag_q.pop_front();
               automatic logic [31:0] d0 = er_data_q.pop_front();
               automatic logic s0 = er_sec_q.pop_front();
               automatic int c0 = er_cyc_q.pop_front();
               chk(res_data == d0, t, "result data", res_data, d0);
               chk(res_second == s0, {t, "/R4"}, "second flag", {31'h0, res_second}, {31'h0, s0});
               chk(cyc == c0, {t, "/R3"}, "result cycle", cyc, c0);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int s;
      string tags [NV];
      tags = '{"R1", "R1", "R1", "R2", "R5", "R5", "R6", "R6", "R6", "R4",
               "R7", "R7", "R7", "R8", "R5", "R4"};
      for (int i = 0; i < 64; i++) begin
         mem[i] = {8'(i) ^ 8'hA5, 8'(i) + 8'h11, 8'(i) ^ 8'h5A, 8'(i) + 8'hC3};
         ref_mem[i] = mem[i];
      end

      // R11: reset state
      repeat (3) @(negedge clk);
      chk(bus_req == 1'b0, "R11", "bus_req in reset", {31'h0, bus_req}, 32'h0);
      chk(res_valid == 1'b0, "R11", "res_valid in reset", {31'h0, res_valid}, 32'h0);
      chk(iss_ready == 1'b1, "R11", "iss_ready in reset", {31'h0, iss_ready}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_req == 1'b0 && res_valid == 1'b0 && iss_ready == 1'b1, "R11",
          "idle after reset", {29'h0, bus_req, res_valid, iss_ready}, 32'h1);

      for (int i = 0; i < NV; i++) begin
         issue(VECS[i], tags[i], s);
         chk(s == 0, "R9", "stall on isolated issue", s, 0);
         idle(4);
      end

      // Back-to-back stream: word load, dword load, byte load, word store, reload (R9, R10)
      begin
         int s0, s1, s2, s3, s4;
         issue('{1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 32'h20, 32'h0, 16'h0000, 32'h0, 32'h0}, "R3", s0);
         issue('{1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 32'h28, 32'h0, 16'h0000, 32'h0, 32'h0}, "R4", s1);
         issue('{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h32, 32'h0, 16'h0000, 32'h0, 32'h0}, "R5", s2);
         issue('{1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 32'h20, 32'h0, 16'h0000, 32'h5A5AF00F, 32'h0}, "R10", s3);
         issue('{1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 32'h20, 32'h0, 16'h0000, 32'h0, 32'h0}, "R3", s4);
         idle(6);
         chk(s0 == 0 && s1 == 0, "R9", "stalls before dword", s0 + s1, 0);
         chk(s2 == 1, "R9", "stall after dword", s2, 1);
         chk(s3 == 0 && s4 == 0, "R9", "stalls after recovery", s3 + s4, 0);
      end

      chk(er_data_q.size() == 0, "R10", "results left outstanding", er_data_q.size(), 0);
      chk(eb_addr_q.size() == 0, "R1", "beats left outstanding", eb_addr_q.size(), 0);
      for (int i = 0; i < 64; i++)
         chk(mem[i] == ref_mem[i], "R7", "memory image", mem[i], ref_mem[i]);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule